// File: doc/BRIEF.md
# Precise Pipeline Trap Controller

This block sits next to a five-stage in-order pipeline and turns the exception requests raised by the stages into one precise trap. Every stage reports, each cycle, whether its instruction has faulted, a 5-bit cause code and that instruction's program counter. When one or more stages fault, the block picks the oldest faulting instruction, that is, the one furthest down the pipeline. In the same cycle it turns that stage and every younger stage into bubbles and steers fetch to a fixed handler vector. At the next clock edge it records the chosen PC in a saved-PC register and the chosen code in a cause register.

Faults in younger stages are dropped when an older one is taken. Those instructions are flushed, and they fault again if they are fetched again. A return request from the handler steers fetch back to the saved PC. The faulting instruction then runs again from scratch. The handler may instead end the program and never raise the return request.

Stage indices grow with age: 0 is fetch, 1 decode, 2 execute, 3 memory and 4 writeback. The cause codes in use are 0 (interrupt), 4 (address error on a load), 5 (address error on a store), 10 (reserved opcode) and 12 (arithmetic overflow).

Top module: `precise_trap_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `saved_pc` and `trap_cause` become 0. With no fault and no return request, `redirect_valid` and `flush_mask` are 0.
- R2: In a cycle with no fault bit set and `ret_req` low, `trap_taken`, `redirect_valid` and `flush_mask` are 0, and `saved_pc` and `trap_cause` keep their values across the next edge.
- R3: When several stages fault in the same cycle, the highest-indexed one is selected, and `trap_stage` shows its index (4 = writeback down to 0 = fetch). Faults in lower-indexed stages have no effect on the recorded state.
- R4: In the cycle of a trap, `flush_mask` bit i is 1 exactly for i less than or equal to the selected stage index, so the mask is a contiguous run from bit 0.
- R5: In the cycle of a trap, `trap_taken` and `redirect_valid` are 1 and `redirect_pc` is 0x80000180, with no register in the path.
- R6: At the edge that ends a trap cycle, `saved_pc` loads the PC of the selected stage.
- R7: At the edge that ends a trap cycle, `trap_cause` loads the 5-bit cause code of the selected stage unchanged.
- R8: With `ret_req` high and no fault, `redirect_valid` is 1, `redirect_pc` equals `saved_pc`, `flush_mask` is 0, and `saved_pc` and `trap_cause` do not change at the next edge.
- R9: If `ret_req` and a fault arrive in the same cycle, the trap wins: the redirect goes to 0x80000180 and the registers load the fault's PC and cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_fault | input | 5 | Fault flag per stage, bit 4 = writeback (oldest), bit 0 = fetch |
| stage_cause | input | 25 | Cause codes, 5 bits per stage, stage i at bits [5i+4:5i] |
| stage_pc | input | 160 | Instruction PCs, 32 bits per stage, stage i at bits [32i+31:32i] |
| ret_req | input | 1 | Return-from-handler request |
| trap_taken | output | 1 | A trap is taken this cycle |
| trap_stage | output | 3 | Index of the selected faulting stage |
| flush_mask | output | 5 | Stages to turn into bubbles this cycle |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | New fetch address |
| saved_pc | output | 32 | Saved PC of the last trapped instruction |
| trap_cause | output | 5 | Cause code of the last trap |

## Verification
Random fault patterns, with each stage faulting about a quarter of the time, mostly produce a single fault or a pair of faults. These show whether the selection follows pipeline age rather than bit order or arrival. Directed patterns cover the extremes. All five stages faulting at once must pick writeback and flush everything. Fetch faulting alone must flush only bit 0. The bench also sends a return request on its own and one in the same cycle as a fault: the first checks that the return uses the stored PC and leaves it unchanged, and the second checks that a trap outranks a return.

// File: rtl/trap_pkg.sv
// Package: shared constants and types for the precise trap controller.
// Assumes stage index grows with instruction age (0 = fetch).
package trap_pkg;
    localparam int CAUSE_W = 5;
    typedef logic [CAUSE_W-1:0] cause_t;

    // Cause codes recorded in the cause register
    localparam cause_t CAUSE_INTERRUPT   = 5'd0;
    localparam cause_t CAUSE_LOAD_ADDR   = 5'd4;
    localparam cause_t CAUSE_STORE_ADDR  = 5'd5;
    localparam cause_t CAUSE_BAD_OPCODE  = 5'd10;
    localparam cause_t CAUSE_OVERFLOW    = 5'd12;

    // Kind of fetch redirect requested this cycle
    typedef enum logic [1:0] {
        REDIR_NONE   = 2'd0,
        REDIR_TRAP   = 2'd1,
        REDIR_RETURN = 2'd2
    } redir_e;
endpackage

// File: rtl/oldest_pick.sv
// Module: oldest_pick
// Picks the oldest faulting stage (highest index) and builds the flush mask
// covering that stage and every younger one. Purely combinational.
// Assumes bit N-1 of fault_vec is the oldest stage.
module oldest_pick #(
    parameter int N     = 5,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     fault_vec,
    output logic             any_fault,
    output logic [N-1:0]     win_onehot,
    output logic [SEL_W-1:0] win_idx,
    output logic [N-1:0]     flush
);
    // older_hit[i] is set when some stage older than i faults
    logic [N-1:0] older_hit;

    assign older_hit[N-1] = 1'b0;

    genvar g;
    generate
        for (g = N - 2; g >= 0; g--) begin : g_chain
            assign older_hit[g] = older_hit[g+1] | fault_vec[g+1];
        end
        for (g = 0; g < N; g++) begin : g_win
            assign win_onehot[g] = fault_vec[g] & ~older_hit[g];
            assign flush[g]      = fault_vec[g] | older_hit[g];
        end
    endgenerate

    assign any_fault = |fault_vec;

    // Encode the one-hot winner into a stage index
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (win_onehot[i]) win_idx = SEL_W'(i);
        end
    end
endmodule

// File: rtl/stage_select.sv
// Module: stage_select
// AND-OR multiplexer that pulls one W-bit field out of a flat per-stage
// vector using a one-hot select. Assumes sel has at most one bit set.
module stage_select #(
    parameter int N = 5,
    parameter int W = 32
) (
    input  logic [N*W-1:0] flat_in,
    input  logic [N-1:0]   sel,
    output logic [W-1:0]   field_out
);
    logic [W-1:0] masked [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_mask
            assign masked[g] = flat_in[g*W +: W] & {W{sel[g]}};
        end
    endgenerate

    // OR-reduce the masked fields
    always_comb begin
        field_out = '0;
        for (int i = 0; i < N; i++) field_out = field_out | masked[i];
    end
endmodule

// File: rtl/trap_regs.sv
// Module: trap_regs
// Holds the saved PC and the cause code. Both load together on a trap.
// Synchronous active-low reset clears both.
module trap_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [CAUSE_W-1:0] cause_in,
    output logic [XLEN-1:0]    pc_q,
    output logic [CAUSE_W-1:0] cause_q
);
    // Capture the selected PC and cause when a trap is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            cause_q <= '0;
        end else if (load) begin
            pc_q    <= pc_in;
            cause_q <= cause_in;
        end
    end
endmodule

// File: rtl/redirect_ctl.sv
// Module: redirect_ctl
// Decides the fetch redirect: a trap goes to the handler vector, a return
// goes to the saved PC, and a trap outranks a return. Combinational.
module redirect_ctl
    import trap_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter logic [31:0] HANDLER = 32'h8000_0180
) (
    input  logic            trap,
    input  logic            ret,
    input  logic [XLEN-1:0] saved,
    output redir_e          kind,
    output logic            valid,
    output logic [XLEN-1:0] target
);
    // Classify the redirect with the trap taking priority
    always_comb begin
        if (trap)     kind = REDIR_TRAP;
        else if (ret) kind = REDIR_RETURN;
        else          kind = REDIR_NONE;
    end

    // Produce the target address for the chosen redirect kind
    always_comb begin
        unique case (kind)
            REDIR_TRAP:   target = XLEN'(HANDLER);
            REDIR_RETURN: target = saved;
            default:      target = '0;
        endcase
    end

    assign valid = (kind != REDIR_NONE);
endmodule

// File: rtl/precise_trap_ctrl.sv
// Module: precise_trap_ctrl (top)
// Turns per-stage fault reports into one precise trap. The oldest fault is
// selected, the flush mask and handler redirect come out in the same cycle,
// and the PC and cause are registered at the following edge.
// Assumes stage index 0 = fetch and stage NSTAGE-1 = writeback.
module precise_trap_ctrl
    import trap_pkg::*;
#(
    parameter int          NSTAGE  = 5,
    parameter int          XLEN    = 32,
    parameter logic [31:0] HANDLER = 32'h8000_0180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSTAGE-1:0]           stage_fault,
    input  logic [NSTAGE*CAUSE_W-1:0]   stage_cause,
    input  logic [NSTAGE*XLEN-1:0]      stage_pc,
    input  logic                        ret_req,
    output logic                        trap_taken,
    output logic [$clog2(NSTAGE)-1:0]   trap_stage,
    output logic [NSTAGE-1:0]           flush_mask,
    output logic                        redirect_valid,
    output logic [XLEN-1:0]             redirect_pc,
    output logic [XLEN-1:0]             saved_pc,
    output logic [CAUSE_W-1:0]          trap_cause
);
    localparam int SEL_W = $clog2(NSTAGE);

    logic [NSTAGE-1:0]  win_oh;
    logic [XLEN-1:0]    sel_pc;
    logic [CAUSE_W-1:0] sel_cause;
    redir_e             redir_kind;

    oldest_pick #(.N(NSTAGE), .SEL_W(SEL_W)) u_pick (
        .fault_vec  (stage_fault),
        .any_fault  (trap_taken),
        .win_onehot (win_oh),
        .win_idx    (trap_stage),
        .flush      (flush_mask)
    );

    stage_select #(.N(NSTAGE), .W(XLEN)) u_pc_sel (
        .flat_in   (stage_pc),
        .sel       (win_oh),
        .field_out (sel_pc)
    );

    stage_select #(.N(NSTAGE), .W(CAUSE_W)) u_cause_sel (
        .flat_in   (stage_cause),
        .sel       (win_oh),
        .field_out (sel_cause)
    );

    trap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trap_taken),
        .pc_in    (sel_pc),
        .cause_in (sel_cause),
        .pc_q     (saved_pc),
        .cause_q  (trap_cause)
    );

    redirect_ctl #(.XLEN(XLEN), .HANDLER(HANDLER)) u_redir (
        .trap   (trap_taken),
        .ret    (ret_req),
        .saved  (saved_pc),
        .kind   (redir_kind),
        .valid  (redirect_valid),
        .target (redirect_pc)
    );
endmodule

// File: rtl/precise_trap_ctrl_chk.sv
// Module: precise_trap_ctrl_chk
// Assertion checker bound to precise_trap_ctrl; observes ports only.
module precise_trap_ctrl_chk #(
    parameter int          NSTAGE  = 5,
    parameter int          XLEN    = 32,
    parameter int          CAUSE_W = 5,
    parameter logic [31:0] HANDLER = 32'h8000_0180
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NSTAGE-1:0]         stage_fault,
    input logic [NSTAGE*CAUSE_W-1:0] stage_cause,
    input logic [NSTAGE*XLEN-1:0]    stage_pc,
    input logic                      ret_req,
    input logic                      trap_taken,
    input logic [NSTAGE-1:0]         flush_mask,
    input logic                      redirect_valid,
    input logic [XLEN-1:0]           redirect_pc,
    input logic [XLEN-1:0]           saved_pc,
    input logic [CAUSE_W-1:0]        trap_cause
);
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_fault == '0 && !ret_req) |-> (!redirect_valid && flush_mask == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_fault == '0 && !ret_req) |=> ($stable(saved_pc) && $stable(trap_cause)));

    assert_oldest_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_fault[NSTAGE-1] |=> saved_pc == $past(stage_pc[NSTAGE*XLEN-1 -: XLEN]));

    assert_flush_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (flush_mask[0] && ((flush_mask & (flush_mask + 1'b1)) == '0)));

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (redirect_valid && redirect_pc == XLEN'(HANDLER)));

    assert_oldest_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stage_fault[NSTAGE-1] |=> trap_cause == $past(stage_cause[NSTAGE*CAUSE_W-1 -: CAUSE_W]));

    assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && stage_fault == '0) |-> (redirect_valid && redirect_pc == saved_pc && flush_mask == '0));

    assert_return_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && stage_fault == '0) |=> $stable(saved_pc));

    assert_trap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && stage_fault != '0) |-> redirect_pc == XLEN'(HANDLER));
endmodule

bind precise_trap_ctrl precise_trap_ctrl_chk #(
    .NSTAGE(NSTAGE), .XLEN(XLEN), .CAUSE_W(trap_pkg::CAUSE_W), .HANDLER(HANDLER)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stage_fault    (stage_fault),
    .stage_cause    (stage_cause),
    .stage_pc       (stage_pc),
    .ret_req        (ret_req),
    .trap_taken     (trap_taken),
    .flush_mask     (flush_mask),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .saved_pc       (saved_pc),
    .trap_cause     (trap_cause)
);

// File: tb/tb_precise_trap_ctrl.sv
module tb_precise_trap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   stage_fault = '0;
    logic [NS*5-1:0] stage_cause = '0;
    logic [NS*32-1:0] stage_pc = '0;
    logic            ret_req = 1'b0;
    logic            trap_taken, redirect_valid;
    logic [2:0]      trap_stage;
    logic [NS-1:0]   flush_mask;
    logic [31:0]     redirect_pc, saved_pc;
    logic [4:0]      trap_cause;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] m_pc = '0;
    logic [4:0]  m_cause = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    precise_trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stage_fault(stage_fault),
        .stage_cause(stage_cause), .stage_pc(stage_pc), .ret_req(ret_req),
        .trap_taken(trap_taken), .trap_stage(trap_stage), .flush_mask(flush_mask),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .saved_pc(saved_pc), .trap_cause(trap_cause)
    );

    function automatic int oldest(logic [NS-1:0] v);
        for (int i = NS - 1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [NS-1:0] exp_flush(int k);
        return (k < 0) ? '0 : NS'((1 << (k + 1)) - 1);
    endfunction

    function automatic logic [4:0] pick_code(int r);
        case (r % 5)
            0: return 5'd0;
            1: return 5'd4;
            2: return 5'd5;
            3: return 5'd10;
            default: return 5'd12;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check outputs for current inputs (called mid-cycle), then advance a cycle
    task automatic step(string tag);
        int k;
        k = oldest(stage_fault);
        #1;
        check({tag, " R2/R3 trap_taken"}, 64'(trap_taken), 64'(k >= 0));
        check({tag, " R4 flush"}, 64'(flush_mask), 64'(exp_flush(k)));
        if (k >= 0) begin
            check({tag, " R3 stage"}, 64'(trap_stage), 64'(k));
            check({tag, " R5/R9 redirect"}, {31'd0, redirect_valid, redirect_pc}, {31'd0, 1'b1, VEC});
        end else if (ret_req) begin
            check({tag, " R8 return"}, {31'd0, redirect_valid, redirect_pc}, {31'd0, 1'b1, m_pc});
        end else begin
            check({tag, " R2 no redirect"}, 64'(redirect_valid), 64'd0);
        end
        check({tag, " R6 saved_pc"}, 64'(saved_pc), 64'(m_pc));
        check({tag, " R7 cause"}, 64'(trap_cause), 64'(m_cause));
        @(posedge clk);
        if (k >= 0) begin
            m_pc    = stage_pc[k*32 +: 32];
            m_cause = stage_cause[k*5 +: 5];
        end
        @(negedge clk);
    endtask

    task automatic drive(logic [NS-1:0] f, logic r, int seed);
        stage_fault = f;
        ret_req = r;
        for (int i = 0; i < NS; i++) begin
            stage_pc[i*32 +: 32]   = 32'h0040_0000 + 32'((seed * 64 + i * 4) & 32'hffff);
            stage_cause[i*5 +: 5]  = pick_code(seed + i);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 saved_pc reset", 64'(saved_pc), 64'd0);
        check("R1 cause reset", 64'(trap_cause), 64'd0);
        check("R1 no redirect", 64'(redirect_valid), 64'd0);
        check("R1 flush idle", 64'(flush_mask), 64'd0);
        rst_n = 1'b1;

        // R3 R4: all stages fault, writeback wins
        drive(5'b11111, 1'b0, 3); step("all");
        // R4: fetch alone
        drive(5'b00001, 1'b0, 7); step("fetch");
        // R8: return alone
        drive(5'b00000, 1'b1, 9); step("ret");
        // R9: return and fault together
        drive(5'b00100, 1'b1, 11); step("ret+trap");
        drive(5'b00000, 1'b1, 13); step("ret2");
        // R2: idle
        drive(5'b00000, 1'b0, 15); step("idle");
        drive(5'b01010, 1'b0, 17); step("pair");

        for (int n = 0; n < 400; n++) begin
            logic [NS-1:0] f;
            for (int i = 0; i < NS; i++) f[i] = ($urandom % 4) == 0;
            drive(f, ($urandom % 8) == 0, int'($urandom % 1000));
            step("rand");
        end
        drive('0, 1'b0, 0); step("final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule